// File: doc/BRIEF.md
# Prefixed Numeric Token Parser

This block is a streaming lexer for one numeric argument of a text command line. Bytes arrive one at a time, each marked by a valid strobe, as they come off a serial command link. A lowercase prefix sets the radix of the token:

- `0x` selects hexadecimal.
- `0b` selects binary.
- A leading `0` followed by more digits selects octal.
- A leading nonzero digit selects decimal.

The two-character text `-1` is a separate marker. It means "use the default" and is flagged on its own output.

A token ends on a terminator byte. The terminators are any whitespace byte, a comma, or a question mark. When the token is good, a one-cycle done pulse carries the 32-bit value. When it is bad, a one-cycle error pulse is raised instead.

After a syntax error the parser discards everything up to the next whitespace byte, so a bad argument cannot corrupt the one that follows. Because the comma and question mark are accepted as terminators, a command decoder can call the parser once per field of an argument list.

Top module: `numtok_parser`

## Requirements
- R1: `0x` followed by one or more hex digits (0-9, a-f, A-F in any mix) is returned as a hexadecimal value.
- R2: `0b` followed by one or more of 0/1 is returned as a binary value; any other digit after `0b` is a syntax error.
- R3: A `0` followed by digits 0-7 is octal. A lone `0` returns zero. The digits 8 or 9 after a leading `0` are a syntax error.
- R4: A token starting with 1-9 is decimal and accepts 0-9 after its first digit.
- R5: The text `-1` gives a done pulse with optval_o high and value_o all ones. A `-` followed by anything else is an error.
- R6: A token ends on a space, tab, LF, VT, FF or CR (0x09-0x0D, 0x20), or on `,` (0x2C) or `?` (0x3F). Whitespace before a token gives no pulse.
- R7: Prefixes are case sensitive: `0X` and `0B` are syntax errors.
- R8: After a syntax error, every byte up to the next whitespace byte is discarded, including `,` and `?`. The error pulse comes on that whitespace byte, and the next token parses normally.
- R9: A value that does not fit in 32 bits gives an error pulse at its terminator.
- R10: A prefix or a `-` with no digit before the terminator gives an error pulse.
- R11: done_o and error_o rise in the clock cycle after the edge that accepts the terminator byte, last exactly one cycle, and are never high together. Bytes presented while valid_i is low have no effect.
- R12: A `,` or `?` received while no token is in progress gives an error pulse at once.
- R13: value_o changes only together with a done pulse and holds its last result otherwise. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | byte_i carries a byte this cycle |
| byte_i | input | 8 | ASCII input byte |
| done_o | output | 1 | One-cycle pulse: a token was accepted |
| error_o | output | 1 | One-cycle pulse: a token was rejected |
| optval_o | output | 1 | With done_o: the token was the default marker `-1` |
| value_o | output | 32 | Value of the last accepted token |

## Verification
A wrong state or radix register stays hidden while digits stream in. It shows up only at the terminator byte, one cycle later, as a wrong value, a missing pulse, or the wrong kind of pulse. A wrong overflow flag likewise surfaces only as a done pulse where an error pulse was due.

A skip state that ends too early shows up on the next terminator. The symptom is an extra error pulse, or a pulse that lands on a comma inside the discarded text. Every token in the stimulus ends with a known terminator, so each of these faults is seen at most one byte after the token ends.

// File: rtl/numtok_pkg.sv
package numtok_pkg;
  typedef enum logic [1:0] {
    RDX_HEX = 2'd0,
    RDX_DEC = 2'd1,
    RDX_OCT = 2'd2,
    RDX_BIN = 2'd3
  } radix_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ZERO  = 3'd1,
    S_PFX   = 3'd2,
    S_DIG   = 3'd3,
    S_MINUS = 3'd4,
    S_MONE  = 3'd5,
    S_SKIP  = 3'd6
  } lex_st_e;

  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_ONE   = 8'h31;
  localparam logic [7:0] CH_LOW_X = 8'h78;
  localparam logic [7:0] CH_LOW_B = 8'h62;
  localparam logic [7:0] CH_DASH  = 8'h2D;
  localparam logic [7:0] CH_COMMA = 8'h2C;
  localparam logic [7:0] CH_QUERY = 8'h3F;
  localparam logic [7:0] CH_SPACE = 8'h20;
endpackage

// File: rtl/numtok_classify.sv
module numtok_classify (
  input  logic [7:0] byte_i,
  output logic       ws_o,
  output logic       sep_o,
  output logic       dec_o,
  output logic       hex_o,
  output logic [3:0] dval_o
);
  import numtok_pkg::*;

  logic lc_af, uc_af;

  always_comb begin
    ws_o   = (byte_i == CH_SPACE) || (byte_i >= 8'h09 && byte_i <= 8'h0D);
    sep_o  = (byte_i == CH_COMMA) || (byte_i == CH_QUERY);
    dec_o  = (byte_i >= 8'h30) && (byte_i <= 8'h39);
    lc_af  = (byte_i >= 8'h61) && (byte_i <= 8'h66);
    uc_af  = (byte_i >= 8'h41) && (byte_i <= 8'h46);
    hex_o  = dec_o || lc_af || uc_af;
    dval_o = byte_i[3:0];
    if (lc_af || uc_af) dval_o = byte_i[3:0] + 4'd9;  // 'a'/'A' low nibble 1 -> 10
  end
endmodule

// File: rtl/numtok_accum.sv
module numtok_accum #(
  parameter int W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 step_i,
  input  numtok_pkg::radix_e   radix_i,
  input  logic [3:0]           digit_i,
  output logic [W-1:0]         acc_o,
  output logic                 ovf_o
);
  import numtok_pkg::*;

  localparam int XW = W + 4;  // room for one radix-16 shift

  logic [XW-1:0] base, wide;

  always_comb begin
    base = {4'd0, acc_o};
    unique case (radix_i)
      RDX_HEX: wide = base << 4;
      RDX_OCT: wide = base << 3;
      RDX_BIN: wide = base << 1;
      default: wide = (base << 3) + (base << 1);
    endcase
    wide = wide + {{(XW-4){1'b0}}, digit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (load_i) begin
      acc_o <= {{(W-4){1'b0}}, digit_i};
      ovf_o <= 1'b0;
    end else if (step_i) begin
      acc_o <= wide[W-1:0];
      ovf_o <= ovf_o | (|wide[XW-1:W]);
    end
  end
endmodule

// File: rtl/numtok_parser.sv
module numtok_parser #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [7:0]   byte_i,
  output logic         done_o,
  output logic         error_o,
  output logic         optval_o,
  output logic [W-1:0] value_o
);
  import numtok_pkg::*;

  lex_st_e st_q, st_d;
  radix_e  rdx_q, rdx_d;
  logic ws, sep, dec, hex, term, dig_ok;
  logic [3:0] dval;
  logic load, step, fin_ok, fin_err, fin_opt;
  logic [W-1:0] acc;
  logic ovf;

  numtok_classify u_cls (
    .byte_i(byte_i), .ws_o(ws), .sep_o(sep), .dec_o(dec), .hex_o(hex), .dval_o(dval)
  );

  numtok_accum #(.W(W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .radix_i(rdx_d), .digit_i(dval), .acc_o(acc), .ovf_o(ovf)
  );

  assign term = ws || sep;

  always_comb begin
    unique case (rdx_q)
      RDX_HEX: dig_ok = hex;
      RDX_OCT: dig_ok = dec && (dval < 4'd8);
      RDX_BIN: dig_ok = dec && (dval < 4'd2);
      default: dig_ok = dec;
    endcase
  end

  always_comb begin
    st_d = st_q; rdx_d = rdx_q;
    load = 1'b0; step = 1'b0;
    fin_ok = 1'b0; fin_err = 1'b0; fin_opt = 1'b0;
    if (valid_i) begin
      unique case (st_q)
        S_IDLE: begin
          if (ws) ;
          else if (sep) fin_err = 1'b1;
          else if (byte_i == CH_ZERO) begin load = 1'b1; st_d = S_ZERO; end
          else if (dec) begin load = 1'b1; rdx_d = RDX_DEC; st_d = S_DIG; end
          else if (byte_i == CH_DASH) st_d = S_MINUS;
          else st_d = S_SKIP;
        end
        S_ZERO: begin
          if (term) fin_ok = 1'b1;
          else if (byte_i == CH_LOW_X) begin rdx_d = RDX_HEX; st_d = S_PFX; end
          else if (byte_i == CH_LOW_B) begin rdx_d = RDX_BIN; st_d = S_PFX; end
          else if (dec && dval < 4'd8) begin rdx_d = RDX_OCT; step = 1'b1; st_d = S_DIG; end
          else st_d = S_SKIP;
        end
        S_PFX: begin
          if (term) fin_err = 1'b1;
          else if (dig_ok) begin step = 1'b1; st_d = S_DIG; end
          else st_d = S_SKIP;
        end
        S_DIG: begin
          if (term) begin fin_ok = !ovf; fin_err = ovf; end
          else if (dig_ok) step = 1'b1;
          else st_d = S_SKIP;
        end
        S_MINUS: begin
          if (term) fin_err = 1'b1;
          else if (byte_i == CH_ONE) st_d = S_MONE;
          else st_d = S_SKIP;
        end
        S_MONE: begin
          if (term) begin fin_ok = 1'b1; fin_opt = 1'b1; end
          else st_d = S_SKIP;
        end
        default: begin  // S_SKIP: only whitespace ends discard
          if (ws) fin_err = 1'b1;
        end
      endcase
      if (fin_ok || fin_err) st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      rdx_q    <= RDX_DEC;
      done_o   <= 1'b0;
      error_o  <= 1'b0;
      optval_o <= 1'b0;
      value_o  <= '0;
    end else begin
      st_q     <= st_d;
      rdx_q    <= rdx_d;
      done_o   <= fin_ok;
      error_o  <= fin_err;
      optval_o <= fin_opt;
      if (fin_ok) value_o <= fin_opt ? '1 : acc;
    end
  end
endmodule

// File: rtl/numtok_parser_chk.sv
module numtok_parser_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         done_o,
  input logic         error_o,
  input logic         optval_o,
  input logic [W-1:0] value_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));  // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R11
  AST_IDLE_INPUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(done_o || error_o));  // R11
  AST_OPT_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    optval_o |-> (done_o && value_o == '1));  // R5
  AST_VALUE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(value_o) |-> done_o);  // R13
endmodule

bind numtok_parser numtok_parser_chk #(.W(W)) u_chk (.*);

// File: tb/sim_numtok_parser.sv
module sim_numtok_parser;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [7:0] din = 8'h00;
  logic done, err, opt;
  logic [W-1:0] val;

  int checks = 0;
  int fails = 0;

  typedef struct {
    bit           is_err;
    bit           opt;
    logic [W-1:0] val;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  numtok_parser #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .byte_i(din),
    .done_o(done), .error_o(err), .optval_o(opt), .value_o(val)
  );

  // monitor: pops one expectation per pulse
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected pulse done=%0b err=%0b val=%h exp=no pulse", done, err, val);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (err != e.is_err || done == e.is_err ||
            (!e.is_err && (val != e.val || opt != e.opt))) begin
          fails++;
          $display("FAIL %s got done=%0b err=%0b opt=%0b val=%h exp err=%0b opt=%0b val=%h",
                   e.tag, done, err, opt, val, e.is_err, e.opt, e.val);
        end
      end
    end
  end

  task automatic put(input logic [7:0] b, input bit v = 1'b1);
    @(negedge clk);
    valid = v;
    din   = b;
  endtask

  task automatic tok(input string s, input bit is_err, input bit o,
                     input logic [W-1:0] v, input string tag);
    exp_t e;
    e.is_err = is_err; e.opt = o; e.val = v; e.tag = tag;
    q.push_back(e);
    for (int i = 0; i < s.len(); i++) put(s[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(8'h00, 1'b0);
  endtask

  task automatic direct(input bit ok, input string msg, input logic [W-1:0] a,
                        input logic [W-1:0] x);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", msg, a, x);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R13 reset state
    direct(!done && !err && !opt, "R13 reset pulses", {29'd0, done, err, opt}, '0);
    direct(val == '0, "R13 reset value", val, '0);
    rst_n = 1'b1;
    idle(2);

    tok("0x1aF ", 0, 0, 32'h1AF, "R1 mixed-case hex");
    tok("0xDEADBEEF,", 0, 0, 32'hDEADBEEF, "R1 hex full width comma");
    tok("0b1011\t", 0, 0, 32'hB, "R2 binary tab");
    tok("0b102 ", 1, 0, '0, "R2 bad binary digit");
    tok("017\n", 0, 0, 32'd15, "R3 octal");
    tok("0 ", 0, 0, 32'd0, "R3 lone zero");
    tok("08 ", 1, 0, '0, "R3 digit 8 after zero");
    tok("4294967295\r", 0, 0, 32'hFFFFFFFF, "R4 decimal max");
    tok("905?", 0, 0, 32'd905, "R4 decimal query term");
    tok("-1,", 0, 1, 32'hFFFFFFFF, "R5 default marker");
    tok("-2 ", 1, 0, '0, "R5 dash other");
    tok("   5 ", 0, 0, 32'd5, "R6 leading whitespace");
    tok("0X12 ", 1, 0, '0, "R7 uppercase X");
    tok("0B1 ", 1, 0, '0, "R7 uppercase B");
    tok("12a4,5? ", 1, 0, '0, "R8 skip through separators");
    tok("7?", 0, 0, 32'd7, "R8 resume after skip");
    tok("4294967296 ", 1, 0, '0, "R9 decimal overflow");
    tok("0x123456789 ", 1, 0, '0, "R9 hex overflow");
    idle(2);
    // R13 value held after errors
    direct(val == 32'd7, "R13 value held after error", val, 32'd7);
    tok("0x ", 1, 0, '0, "R10 hex prefix no digit");
    tok("0b,", 1, 0, '0, "R10 bin prefix no digit");
    tok("- ", 1, 0, '0, "R10 lone dash");
    tok(",", 1, 0, '0, "R12 comma in idle");
    tok("?", 1, 0, '0, "R12 query in idle");
    // R11 bytes with valid low ignored
    begin
      exp_t e;
      e.is_err = 0; e.opt = 0; e.val = 32'd12; e.tag = "R11 valid low ignored";
      q.push_back(e);
      put("1"); put("x", 1'b0); put(" ", 1'b0); put("2"); put(" ");
    end
    idle(4);
    direct(q.size() == 0, "R11 all expected pulses seen", q.size(), 0);
    direct(val == 32'd12, "R13 final value", val, 32'd12);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule